// File: doc/BRIEF.md
# Message-Signaled Interrupt Request Controller

This block collects interrupt events from up to 32 local sources and turns them into message-signaled interrupt requests towards a PCIe transaction layer. Each request carries a vector number and a traffic class. The block drives the request line and holds it until the transaction layer acknowledges it. Only after that acknowledge does it present the next request.

Host software may grant fewer vectors than the function asked for. The granted count arrives as a log2 code in the MSI control word, and the block folds each source index onto that smaller power-of-two range. An enable bit in the same word stops new requests from starting.

Events that arrive while a request is in flight are kept in a per-source pending register. They are serviced lowest index first. Repeat events from a source that is already pending merge into one request.

Top module: `msi_req_ctrl`

## Requirements
- R1: After reset, `msi_req_o` is low and `msi_vec_o` is 0.
- R2: While `msi_req_o` is high and `msi_ack_i` is low, the request, the vector and the traffic class stay unchanged on the next cycle. `msi_req_o` is low in the cycle after the edge at which the acknowledge is sampled.
- R3: The grant code g is `msi_ctl_i[6:4]`, and the vector sent is the source index with every bit at position g and above cleared. So g=0 always gives vector 0, and g=3 maps source 21 to 5. Codes 5, 6 and 7 grant all 32 vectors.
- R4: While `msi_ctl_i[0]` (enable) is 0, no new request starts. Events that arrive meanwhile stay pending and are requested once enable is 1.
- R5: When several sources are pending, the lowest source index is requested first.
- R6: An event that arrives while a request for another source is outstanding is requested after the current acknowledge.
- R7: Repeat events from a source whose pending bit is already set produce no additional request.
- R8: An event from the source being acknowledged, arriving in the same cycle as the acknowledge, is kept and leads to a new request.
- R9: `msi_tc_o` equals the parameter `MSI_TC` whenever a request is shown.
- R10: `msi_req_o` is low for at least one cycle between two requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt_i | input | NUM_SRC | One pulse per event, one bit per source |
| msi_ctl_i | input | 16 | MSI control word: bit 0 enable, bits 6:4 grant code |
| msi_ack_i | input | 1 | Acknowledge from the transaction layer |
| msi_req_o | output | 1 | Request, held until acknowledged |
| msi_vec_o | output | 5 | Folded vector number |
| msi_tc_o | output | 3 | Traffic class |

## Verification
The hardest case to reach from the ports is an event from the very source being acknowledged, arriving in the acknowledge cycle itself. The pending clear and the new set then meet on one register bit. The bench raises that source's event in the same cycle it raises the acknowledge, and expects a second request for the same vector. Merging is reached the same way: the bench keeps a request waiting without an acknowledge, pulses its source again several times, and then checks that the line stays quiet after a single acknowledge.

// File: rtl/msi_req_pkg.sv
package msi_req_pkg;

    localparam int VEC_W     = 5;
    localparam int TC_W      = 3;
    localparam int CTL_W     = 16;
    localparam int EN_BIT    = 0;
    localparam int GRANT_LSB = 4;
    localparam int GRANT_W   = 3;
    localparam int GRANT_MAX = 5;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } msi_st_e;

endpackage

// File: rtl/msi_pend_reg.sv
module msi_pend_reg #(
    parameter int NUM_SRC = 32,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               clr_vld_i,
    input  logic [IDX_W-1:0]   clr_idx_i,
    output logic [NUM_SRC-1:0] pend_o
);

    logic [NUM_SRC-1:0] pend_d, pend_q;
    logic [NUM_SRC-1:0] clr_mask;

    // one-hot clear mask for the acknowledged source
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr
        assign clr_mask[i] = clr_vld_i && (clr_idx_i == IDX_W'(i));
    end

    // a new event wins over the clear of the same bit
    always_comb begin
        pend_d = (pend_q & ~clr_mask) | evt_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/msi_prio_pick.sv
module msi_prio_pick #(
    parameter int NUM_SRC = 32,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] pend_i,
    output logic               found_o,
    output logic [IDX_W-1:0]   idx_o
);

    // scan from the top down so the lowest set index is left last
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/msi_vec_fold.sv
module msi_vec_fold
    import msi_req_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0]   idx_i,
    input  logic [GRANT_W-1:0] grant_i,
    output logic [VEC_W-1:0]   vec_o
);

    localparam int EXT_W = (IDX_W > VEC_W) ? IDX_W : VEC_W;

    logic [GRANT_W-1:0] g_eff;
    logic [VEC_W-1:0]   keep;
    logic [EXT_W-1:0]   idx_ext;

    assign g_eff   = (grant_i > GRANT_W'(GRANT_MAX)) ? GRANT_W'(GRANT_MAX) : grant_i;
    assign idx_ext = EXT_W'(idx_i);

    // keep bit b only when b lies below the granted log2 count
    for (genvar b = 0; b < VEC_W; b++) begin : g_keep
        assign keep[b] = (GRANT_W'(b) < g_eff);
    end

    assign vec_o = idx_ext[VEC_W-1:0] & keep;

endmodule

// File: rtl/msi_req_ctrl.sv
module msi_req_ctrl
    import msi_req_pkg::*;
#(
    parameter int           NUM_SRC = 32,
    parameter logic [2:0]   MSI_TC  = 3'd0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_evt_i,
    input  logic [15:0]        msi_ctl_i,
    input  logic               msi_ack_i,
    output logic               msi_req_o,
    output logic [4:0]         msi_vec_o,
    output logic [2:0]         msi_tc_o
);

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    typedef struct packed {
        msi_st_e          st;
        logic             req;
        logic [VEC_W-1:0] vec;
        logic [IDX_W-1:0] src;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic [NUM_SRC-1:0] pend;
    logic               found;
    logic [IDX_W-1:0]   pick_idx;
    logic [VEC_W-1:0]   fold_vec;
    logic               clr_vld;
    logic               en;

    assign en      = msi_ctl_i[EN_BIT];
    assign clr_vld = (ctrl_q.st == ST_WAIT) && msi_ack_i;

    msi_pend_reg #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (src_evt_i),
        .clr_vld_i (clr_vld),
        .clr_idx_i (ctrl_q.src),
        .pend_o    (pend)
    );

    msi_prio_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .pend_i  (pend),
        .found_o (found),
        .idx_o   (pick_idx)
    );

    msi_vec_fold #(.IDX_W(IDX_W)) u_fold (
        .idx_i   (pick_idx),
        .grant_i (msi_ctl_i[GRANT_LSB +: GRANT_W]),
        .vec_o   (fold_vec)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        unique case (ctrl_q.st)
            ST_IDLE: begin
                if (en && found) begin
                    ctrl_d.st  = ST_WAIT;
                    ctrl_d.req = 1'b1;
                    ctrl_d.vec = fold_vec;
                    ctrl_d.src = pick_idx;
                end
            end
            ST_WAIT: begin
                if (msi_ack_i) begin
                    ctrl_d.st  = ST_IDLE;
                    ctrl_d.req = 1'b0;
                end
            end
            default: ctrl_d = ctrl_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{st: ST_IDLE, req: 1'b0, vec: '0, src: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign msi_req_o = ctrl_q.req;
    assign msi_vec_o = ctrl_q.vec;
    assign msi_tc_o  = MSI_TC;

endmodule

// File: rtl/msi_req_ctrl_chk.sv
module msi_req_ctrl_chk #(
    parameter logic [2:0] MSI_TC = 3'd0
) (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] msi_ctl_i,
    input logic        msi_ack_i,
    input logic        msi_req_o,
    input logic [4:0]  msi_vec_o,
    input logic [2:0]  msi_tc_o
);

    logic [2:0] g_eff;
    assign g_eff = (msi_ctl_i[6:4] > 3'd5) ? 3'd5 : msi_ctl_i[6:4];

    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        msi_req_o && !msi_ack_i |=> msi_req_o); // R2

    AST_HOLD_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        msi_req_o && !msi_ack_i |=> $stable(msi_vec_o)); // R2

    AST_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        msi_req_o && msi_ack_i |=> !msi_req_o); // R10

    AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !msi_req_o && !msi_ctl_i[0] |=> !msi_req_o); // R4

    AST_VEC_IN_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        !msi_req_o |=> !msi_req_o || ((msi_vec_o >> $past(g_eff)) == 5'd0)); // R3

    AST_TC_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        msi_req_o |-> msi_tc_o == MSI_TC); // R9

endmodule

bind msi_req_ctrl msi_req_ctrl_chk #(.MSI_TC(MSI_TC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .msi_ctl_i (msi_ctl_i),
    .msi_ack_i (msi_ack_i),
    .msi_req_o (msi_req_o),
    .msi_vec_o (msi_vec_o),
    .msi_tc_o  (msi_tc_o)
);

// File: tb/msi_req_ctrl_tb.sv
module msi_req_ctrl_tb;

    localparam int         NSRC = 32;
    localparam logic [2:0] TC   = 3'd5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] evt = '0;
    logic [15:0]     ctl = 16'h0000;
    logic            ack = 1'b0;
    logic            req;
    logic [4:0]      vec;
    logic [2:0]      tc;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    msi_req_ctrl #(.NUM_SRC(NSRC), .MSI_TC(TC)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_evt_i (evt),
        .msi_ctl_i (ctl),
        .msi_ack_i (ack),
        .msi_req_o (req),
        .msi_vec_o (vec),
        .msi_tc_o  (tc)
    );

    function automatic logic [15:0] mk_ctl(input logic en, input logic [2:0] g);
        return {9'd0, g, 3'd0, en};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic [NSRC-1:0] m);
        evt = m;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic wait_req(input string tag);
        for (int i = 0; i < 50; i++) begin
            if (req) break;
            @(negedge clk);
        end
        check(req == 1'b1, tag, req, 1);
    endtask

    task automatic do_ack(input string tag);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        check(req == 1'b0, tag, req, 0);
    endtask

    task automatic quiet(input int n, input string tag);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (req) seen = 1'b1;
        end
        check(!seen, tag, seen, 0);
    endtask

    task automatic t_reset();
        check(req == 1'b0, "R1 req after reset", req, 0);
        check(vec == 5'd0, "R1 vec after reset", vec, 0);
    endtask

    task automatic t_basic_hold();
        ctl = mk_ctl(1'b1, 3'd5);
        pulse(32'h1 << 5);
        wait_req("R2 request raised");
        check(vec == 5'd5, "R3 vec full grant", vec, 5);
        check(tc == TC, "R9 traffic class", tc, TC);
        for (int i = 0; i < 10; i++) @(negedge clk);
        check(req == 1'b1, "R2 req held", req, 1);
        check(vec == 5'd5, "R2 vec held", vec, 5);
        do_ack("R2 drop after ack");
        quiet(10, "R7 no extra request");
    endtask

    task automatic t_fold(input logic [2:0] g, input int src, input int exp, input string tag);
        ctl = mk_ctl(1'b1, g);
        pulse(32'h1 << src);
        wait_req(tag);
        check(vec == 5'(exp), tag, vec, exp);
        do_ack(tag);
        @(negedge clk);
    endtask

    task automatic t_priority();
        ctl = mk_ctl(1'b1, 3'd5);
        pulse((32'h1 << 9) | (32'h1 << 3));
        wait_req("R5 first");
        check(vec == 5'd3, "R5 lowest first", vec, 3);
        do_ack("R10 gap");
        wait_req("R5 second");
        check(vec == 5'd9, "R5 then higher", vec, 9);
        do_ack("R5 ack");
        quiet(5, "R5 done");
    endtask

    task automatic t_enable();
        ctl = mk_ctl(1'b0, 3'd5);
        pulse(32'h1 << 4);
        quiet(20, "R4 disabled no request");
        ctl = mk_ctl(1'b1, 3'd5);
        wait_req("R4 pending issued on enable");
        check(vec == 5'd4, "R4 pending vector", vec, 4);
        do_ack("R4 ack");
    endtask

    task automatic t_during();
        ctl = mk_ctl(1'b1, 3'd5);
        pulse(32'h1);
        wait_req("R6 first");
        pulse(32'h1 << 6);
        check(vec == 5'd0, "R6 current kept", vec, 0);
        do_ack("R6 ack");
        wait_req("R6 latched served");
        check(vec == 5'd6, "R6 latched vector", vec, 6);
        do_ack("R6 ack2");
    endtask

    task automatic t_merge();
        ctl = mk_ctl(1'b1, 3'd5);
        pulse(32'h1 << 2);
        wait_req("R7 first");
        pulse(32'h1 << 2);
        @(negedge clk);
        pulse(32'h1 << 2);
        do_ack("R7 ack");
        quiet(20, "R7 merged single request");
    endtask

    task automatic t_ack_same();
        ctl = mk_ctl(1'b1, 3'd5);
        pulse(32'h1 << 2);
        wait_req("R8 first");
        ack = 1'b1;
        evt = 32'h1 << 2;
        @(negedge clk);
        ack = 1'b0;
        evt = '0;
        check(req == 1'b0, "R10 drop", req, 0);
        wait_req("R8 event on ack kept");
        check(vec == 5'd2, "R8 vector", vec, 2);
        do_ack("R8 ack");
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_hold();
        t_fold(3'd1, 7, 1, "R3 two vectors");
        t_fold(3'd0, 13, 0, "R3 one vector");
        t_fold(3'd3, 21, 5, "R3 eight vectors");
        t_fold(3'd7, 30, 30, "R3 reserved code");
        t_priority();
        t_enable();
        t_during();
        t_merge();
        t_ack_same();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule